// File: doc/BRIEF.md
# Byte-Wide Result Output Handshake Controller

This block takes a converter result of up to 16 bits, with a polarity flag and an overrange flag, and puts it on an 8-bit bus in three byte groups. The high group carries the two flags. The middle group carries result bits 15..8. The low group carries bits 7..0. The bus has an output-enable. Each group also has an enable pin, and there is one shared chip-enable/load pin. These pins change direction with the mode input. The chip drives each of them as an input/output pair: `ctl_drive_o` tells the pad ring which side owns the pins.

With the mode input low, the block is in direct mode. A host drives the three group enables and a master chip-enable, and reads the registered bus one cycle later. With the mode input high, the block owns those pins and hands the result to a UART or a microprocessor one byte at a time. The order is high group, middle group, low group. Each byte waits for the receiver's send input. Each byte goes out with its group enable and a one-clock low load strobe. A handshake starts when a conversion completes while the mode input is high, or at once when the mode input rises. A result that arrives in the middle of a handshake is held back until the running sequence ends.

Top module: `result_byte_link`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ctl_drive_o`, the three group enable outputs, `bus_oe_o` and `bus_o` are all 0, and `ld_n_o` is 1.
- R2: In direct mode (mode low, no sequence running), the group enable outputs stay 0, `ld_n_o` stays 1 and `ctl_drive_o` is 0. One cycle after the direct inputs are sampled, `bus_oe_o` is 1 exactly when at least one group enable input is 1 and `ce_ld_i` is 0.
- R3: In direct mode, `ce_ld_i` high forces `bus_oe_o` to 0 and `bus_o` to 0 on the next cycle, whatever the group enables are.
- R4: The byte values are fixed. The high group is {polarity, overrange, 6'b0}, with polarity on bus bit 7 and overrange on bus bit 6. The middle group is result bits 15..8. The low group is result bits 7..0. In direct mode, if several enables are high, high wins over middle and middle wins over low. Whenever `bus_oe_o` is 0, `bus_o` is 0.
- R5: With the parameter RES_BITS below 16, the result bits at and above RES_BITS read as 0 in every byte. For RES_BITS = 14, bus bits 7..6 of the middle group are 0.
- R6: If the mode input is high and no sequence is running, a conversion-complete pulse latches the new result and starts a handshake on the next clock. `ctl_drive_o` is 1 while the mode input is high or a sequence is running, and returns to 0 once the sequence ends with the mode input low.
- R7: A rising edge on the mode input while no sequence is running starts a handshake of the result already latched. `ctl_drive_o` is 1 on the very next cycle. The sequence runs to the end even if the mode input falls again.
- R8: A handshake sends the high, middle and low groups in that order. Each byte shows up as its own group enable, the matching `bus_o` value, `bus_oe_o` = 1 and `ld_n_o` = 0. All of these last exactly one cycle, and they appear on the cycle after `send_i` is sampled high in that byte's wait step.
- R9: While a handshake waits for `send_i`, `ld_n_o` is 1, `bus_oe_o` is 0 and all group enable outputs are 0.
- R10: In direct mode, a conversion-complete pulse replaces the latched result at once. A pulse that arrives during a handshake does not change the bytes still to be sent. That result is latched when the sequence ends, and if the mode input is high it is sent by the next sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_data_i | input | 16 | Result word from the converter |
| res_pol_i | input | 1 | Result polarity flag |
| res_ovr_i | input | 1 | Result overrange flag |
| res_done_i | input | 1 | One-cycle conversion-complete pulse |
| mode_i | input | 1 | 0 = direct mode, 1 = handshake mode; a rising edge forces a handshake |
| send_i | input | 1 | Receiver ready for the next byte |
| hi_en_i | input | 1 | Direct-mode high group enable |
| mid_en_i | input | 1 | Direct-mode middle group enable |
| lo_en_i | input | 1 | Direct-mode low group enable |
| ce_ld_i | input | 1 | Direct-mode master disable (high blanks the bus) |
| ctl_drive_o | output | 1 | Block drives the enable and load pins |
| hi_en_o | output | 1 | Handshake high group enable |
| mid_en_o | output | 1 | Handshake middle group enable |
| lo_en_o | output | 1 | Handshake low group enable |
| ld_n_o | output | 1 | Handshake load strobe, active low |
| bus_oe_o | output | 1 | Tri-state enable of the byte bus |
| bus_o | output | 8 | Byte bus value |

## Verification
A sequencer stuck in the wrong state, or advancing in the wrong order, shows up at the load strobe. Either a strobe appears with a group enable that does not match the expected order, or a strobe appears without a sampled send. Both are visible within one clock of the faulty step. A wrong latch or pending-result decision shows up as a wrong byte value on the next strobe, or as a sequence that never restarts. A wrong direct-mode decode shows up on `bus_oe_o` or `bus_o` one cycle after the enables change. The bench sweeps every combination of the four direct inputs for several result words. It runs handshakes that are started by a mode pulse, by mode held high, and by a result that was held back. It does all of this at the 16-bit width and at the 14-bit width side by side.

// File: rtl/rbl_pkg.sv
package rbl_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_HI_W,
        SQ_HI_L,
        SQ_MID_W,
        SQ_MID_L,
        SQ_LO_W,
        SQ_LO_L
    } seq_e;

    typedef struct packed {
        logic hi;
        logic mid;
        logic lo;
    } lane_sel_t;
endpackage

// File: rtl/rbl_result_hold.sv
module rbl_result_hold
    import rbl_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              pol_i,
    input  logic              ovr_i,
    input  logic              busy_i,
    output logic [WORD_W-1:0] word_o,
    output logic              pol_o,
    output logic              ovr_o,
    output logic              pend_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              pol;
        logic              ovr;
        logic [WORD_W-1:0] p_word;
        logic              p_pol;
        logic              p_ovr;
        logic              pend;
    } hold_t;

    hold_t h_d, h_q;
    logic [WORD_W-1:0] in_masked;

    generate
        if (RES_BITS < WORD_W) begin : g_narrow
            localparam logic [WORD_W-1:0] KEEP = WORD_W'((1 << RES_BITS) - 1);
            assign in_masked = word_i & KEEP;
        end else begin : g_full
            assign in_masked = word_i;
        end
    endgenerate

    always_comb begin
        h_d = h_q;
        if (!busy_i) begin
            if (done_i) begin
                h_d.word = in_masked;
                h_d.pol  = pol_i;
                h_d.ovr  = ovr_i;
                h_d.pend = 1'b0;
            end else if (h_q.pend) begin
                h_d.word = h_q.p_word;
                h_d.pol  = h_q.p_pol;
                h_d.ovr  = h_q.p_ovr;
                h_d.pend = 1'b0;
            end
        end else if (done_i) begin
            h_d.p_word = in_masked;
            h_d.p_pol  = pol_i;
            h_d.p_ovr  = ovr_i;
            h_d.pend   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign word_o = h_q.word;
    assign pol_o  = h_q.pol;
    assign ovr_o  = h_q.ovr;
    assign pend_o = h_q.pend;
endmodule

// File: rtl/rbl_byte_lane.sv
module rbl_byte_lane
    import rbl_pkg::*;
(
    input  lane_sel_t         sel_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              pol_i,
    input  logic              ovr_i,
    output logic [BYTE_W-1:0] byte_o
);
    always_comb begin
        byte_o = '0;
        if (sel_i.hi) begin
            byte_o = {pol_i, ovr_i, {(BYTE_W-2){1'b0}}};
        end else if (sel_i.mid) begin
            byte_o = word_i[WORD_W-1:BYTE_W];
        end else if (sel_i.lo) begin
            byte_o = word_i[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/result_byte_link.sv
module result_byte_link
    import rbl_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] res_data_i,
    input  logic              res_pol_i,
    input  logic              res_ovr_i,
    input  logic              res_done_i,
    input  logic              mode_i,
    input  logic              send_i,
    input  logic              hi_en_i,
    input  logic              mid_en_i,
    input  logic              lo_en_i,
    input  logic              ce_ld_i,
    output logic              ctl_drive_o,
    output logic              hi_en_o,
    output logic              mid_en_o,
    output logic              lo_en_o,
    output logic              ld_n_o,
    output logic              bus_oe_o,
    output logic [BYTE_W-1:0] bus_o
);
    typedef struct packed {
        seq_e              seq;
        logic              mode_prev;
        logic              ctl;
        lane_sel_t         en;
        logic              ld_n;
        logic              oe;
        logic [BYTE_W-1:0] bus;
    } link_t;

    link_t s_d, s_q;

    logic [WORD_W-1:0] held_word;
    logic              held_pol, held_ovr, pend;
    logic              busy, start;
    lane_sel_t         sel_next;
    logic [BYTE_W-1:0] lane_byte;

    assign busy  = (s_q.seq != SQ_IDLE);
    assign start = !busy && ((mode_i && !s_q.mode_prev) ||
                             (mode_i && (res_done_i || pend)));

    rbl_result_hold #(.RES_BITS(RES_BITS)) hold_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (res_done_i),
        .word_i (res_data_i),
        .pol_i  (res_pol_i),
        .ovr_i  (res_ovr_i),
        .busy_i (busy),
        .word_o (held_word),
        .pol_o  (held_pol),
        .ovr_o  (held_ovr),
        .pend_o (pend)
    );

    rbl_byte_lane lane_i (
        .sel_i  (sel_next),
        .word_i (held_word),
        .pol_i  (held_pol),
        .ovr_i  (held_ovr),
        .byte_o (lane_byte)
    );

    always_comb begin
        s_d           = s_q;
        s_d.mode_prev = mode_i;

        unique case (s_q.seq)
            SQ_IDLE:  if (start)  s_d.seq = SQ_HI_W;
            SQ_HI_W:  if (send_i) s_d.seq = SQ_HI_L;
            SQ_HI_L:              s_d.seq = SQ_MID_W;
            SQ_MID_W: if (send_i) s_d.seq = SQ_MID_L;
            SQ_MID_L:             s_d.seq = SQ_LO_W;
            SQ_LO_W:  if (send_i) s_d.seq = SQ_LO_L;
            SQ_LO_L:              s_d.seq = SQ_IDLE;
            default:              s_d.seq = SQ_IDLE;
        endcase

        if (s_d.seq != SQ_IDLE) begin
            sel_next.hi  = (s_d.seq == SQ_HI_L);
            sel_next.mid = (s_d.seq == SQ_MID_L);
            sel_next.lo  = (s_d.seq == SQ_LO_L);
            s_d.ctl  = 1'b1;
            s_d.en   = sel_next;
            s_d.oe   = |sel_next;
            s_d.ld_n = !(|sel_next);
        end else if (mode_i) begin
            sel_next = '0;
            s_d.ctl  = 1'b1;
            s_d.en   = '0;
            s_d.oe   = 1'b0;
            s_d.ld_n = 1'b1;
        end else begin
            sel_next.hi  = hi_en_i;
            sel_next.mid = mid_en_i;
            sel_next.lo  = lo_en_i;
            s_d.ctl  = 1'b0;
            s_d.en   = '0;
            s_d.oe   = !ce_ld_i && (|sel_next);
            s_d.ld_n = 1'b1;
        end
        s_d.bus = s_d.oe ? lane_byte : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.seq       <= SQ_IDLE;
            s_q.mode_prev <= 1'b0;
            s_q.ctl       <= 1'b0;
            s_q.en        <= '0;
            s_q.ld_n      <= 1'b1;
            s_q.oe        <= 1'b0;
            s_q.bus       <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_drive_o = s_q.ctl;
    assign hi_en_o     = s_q.en.hi;
    assign mid_en_o    = s_q.en.mid;
    assign lo_en_o     = s_q.en.lo;
    assign ld_n_o      = s_q.ld_n;
    assign bus_oe_o    = s_q.oe;
    assign bus_o       = s_q.bus;
endmodule

// File: rtl/rbl_checker.sv
module rbl_checker #(
    parameter int RES_BITS = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       send_i,
    input logic       ctl_drive_o,
    input logic       hi_en_o,
    input logic       mid_en_o,
    input logic       lo_en_o,
    input logic       ld_n_o,
    input logic       bus_oe_o,
    input logic [7:0] bus_o
);
    localparam logic [7:0] MID_KEEP = 8'((1 << (RES_BITS - 8)) - 1);

    // last strobed group: 0 none or low, 1 high, 2 middle
    logic [1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 2'd0;
        end else if (!ld_n_o) begin
            last_q <= hi_en_o ? 2'd1 : (mid_en_o ? 2'd2 : 2'd0);
        end
    end

    assert_quiet_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_drive_o |-> (ld_n_o && !hi_en_o && !mid_en_o && !lo_en_o));

    assert_blank_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (bus_o == 8'h00));

    assert_mid_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n_o && mid_en_o) |-> ((bus_o & ~MID_KEEP) == 8'h00));

    assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n_o |=> ld_n_o);

    assert_strobe_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n_o |-> ($countones({hi_en_o, mid_en_o, lo_en_o}) == 1 && bus_oe_o));

    assert_order_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n_o && mid_en_o) |-> (last_q == 2'd1));

    assert_order_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n_o && lo_en_o) |-> (last_q == 2'd2));

    assert_order_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n_o && hi_en_o) |-> (last_q == 2'd0));

    assert_send_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ld_n_o) |-> $past(send_i));

    assert_hs_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_drive_o && bus_oe_o) |-> !ld_n_o);
endmodule

bind result_byte_link rbl_checker #(.RES_BITS(RES_BITS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .send_i      (send_i),
    .ctl_drive_o (ctl_drive_o),
    .hi_en_o     (hi_en_o),
    .mid_en_o    (mid_en_o),
    .lo_en_o     (lo_en_o),
    .ld_n_o      (ld_n_o),
    .bus_oe_o    (bus_oe_o),
    .bus_o       (bus_o)
);

// File: tb/result_byte_link_tb.sv
module result_byte_link_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data = '0;
    logic        pol = 1'b0, ovr = 1'b0, done = 1'b0;
    logic        mode = 1'b0, send = 1'b0;
    logic        hi_in = 1'b0, mid_in = 1'b0, lo_in = 1'b0, ce_in = 1'b0;

    logic       a_ctl, a_hi, a_mid, a_lo, a_ld, a_oe;
    logic [7:0] a_bus;
    logic       b_ctl, b_hi, b_mid, b_lo, b_ld, b_oe;
    logic [7:0] b_bus;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    result_byte_link #(.RES_BITS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .res_data_i(data), .res_pol_i(pol),
        .res_ovr_i(ovr), .res_done_i(done), .mode_i(mode), .send_i(send),
        .hi_en_i(hi_in), .mid_en_i(mid_in), .lo_en_i(lo_in), .ce_ld_i(ce_in),
        .ctl_drive_o(a_ctl), .hi_en_o(a_hi), .mid_en_o(a_mid), .lo_en_o(a_lo),
        .ld_n_o(a_ld), .bus_oe_o(a_oe), .bus_o(a_bus));

    result_byte_link #(.RES_BITS(14)) dut14_i (
        .clk(clk), .rst_n(rst_n), .res_data_i(data), .res_pol_i(pol),
        .res_ovr_i(ovr), .res_done_i(done), .mode_i(mode), .send_i(send),
        .hi_en_i(hi_in), .mid_en_i(mid_in), .lo_en_i(lo_in), .ce_ld_i(ce_in),
        .ctl_drive_o(b_ctl), .hi_en_o(b_hi), .mid_en_o(b_mid), .lo_en_o(b_lo),
        .ld_n_o(b_ld), .bus_oe_o(b_oe), .bus_o(b_bus));

    // packed view: {ctl, hi, mid, lo, ld_n, oe, bus[7:0]}
    function automatic logic [13:0] pk(logic c, logic h, logic m, logic l,
                                       logic ld, logic oe, logic [7:0] b);
        return {c, h, m, l, ld, oe, b};
    endfunction

    // which: 0 high, 1 middle, 2 low
    function automatic logic [7:0] exp_byte(int which, logic [15:0] w,
                                            logic p, logic o, int bits);
        logic [31:0] mw;
        mw = {16'h0, w} & ((32'd1 << bits) - 32'd1);
        if (which == 0) return {p, o, 6'b0};
        if (which == 1) return mw[15:8];
        return mw[7:0];
    endfunction

    task automatic chk(string req, string what, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_result(logic [15:0] w, logic p, logic o);
        @(negedge clk);
        data = w; pol = p; ovr = o; done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    // called at a negedge; checks one byte of a handshake on both widths
    task automatic hs_byte(string req, int which, logic [15:0] w, logic p, logic o);
        repeat (2) @(posedge clk);
        #1;
        chk("R9", "wait16", pk(a_ctl,a_hi,a_mid,a_lo,a_ld,a_oe,a_bus), pk(1,0,0,0,1,0,8'h00));
        chk("R9", "wait14", pk(b_ctl,b_hi,b_mid,b_lo,b_ld,b_oe,b_bus), pk(1,0,0,0,1,0,8'h00));
        @(negedge clk);
        send = 1'b1;
        @(posedge clk);
        #1;
        chk(req, "byte16", pk(a_ctl,a_hi,a_mid,a_lo,a_ld,a_oe,a_bus),
            pk(1, which==0, which==1, which==2, 0, 1, exp_byte(which, w, p, o, 16)));
        chk(req, "byte14", pk(b_ctl,b_hi,b_mid,b_lo,b_ld,b_oe,b_bus),
            pk(1, which==0, which==1, which==2, 0, 1, exp_byte(which, w, p, o, 14)));
        @(negedge clk);
        send = 1'b0;
    endtask

    task automatic hs_seq(string req, logic [15:0] w, logic p, logic o);
        for (int g = 0; g < 3; g++) hs_byte(req, g, w, p, o);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] words [3];
        words[0] = 16'hA5C3;
        words[1] = 16'hFFFF;
        words[2] = 16'h4001;

        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "rst16", pk(a_ctl,a_hi,a_mid,a_lo,a_ld,a_oe,a_bus), pk(0,0,0,0,1,0,8'h00));
        chk("R1", "rst14", pk(b_ctl,b_hi,b_mid,b_lo,b_ld,b_oe,b_bus), pk(0,0,0,0,1,0,8'h00));
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "post16", pk(a_ctl,a_hi,a_mid,a_lo,a_ld,a_oe,a_bus), pk(0,0,0,0,1,0,8'h00));

        // R2 R3 R4 R5 R10: direct-mode sweep over all enable combinations
        for (int wi = 0; wi < 3; wi++) begin
            logic p, o;
            p = wi[0];
            o = !wi[0];
            load_result(words[wi], p, o);
            for (int k = 0; k < 16; k++) begin
                logic ce, h, m, l, oe;
                int which;
                {ce, h, m, l} = 4'(k);
                @(negedge clk);
                ce_in = ce; hi_in = h; mid_in = m; lo_in = l;
                @(posedge clk);
                #1;
                oe = !ce && (h || m || l);
                which = h ? 0 : (m ? 1 : 2);
                chk(ce ? "R3" : "R2", "direct16", pk(a_ctl,a_hi,a_mid,a_lo,a_ld,a_oe,a_bus),
                    pk(0,0,0,0,1,oe, oe ? exp_byte(which, words[wi], p, o, 16) : 8'h00));
                chk("R5", "direct14", pk(b_ctl,b_hi,b_mid,b_lo,b_ld,b_oe,b_bus),
                    pk(0,0,0,0,1,oe, oe ? exp_byte(which, words[wi], p, o, 14) : 8'h00));
            end
        end
        @(negedge clk);
        ce_in = 1'b0; hi_in = 1'b0; mid_in = 1'b0; lo_in = 1'b0;

        // R7: a mode pulse forces a handshake of the latched result (words[2], pol 0, ovr 1)
        @(negedge clk);
        mode = 1'b1;
        @(posedge clk);
        #1;
        chk("R7", "pulse16", pk(a_ctl,a_hi,a_mid,a_lo,a_ld,a_oe,a_bus), pk(1,0,0,0,1,0,8'h00));
        @(negedge clk);
        mode = 1'b0;
        hs_seq("R8", words[2], 1'b0, 1'b1);
        repeat (2) @(posedge clk);
        #1;
        chk("R6", "release16", pk(a_ctl,a_hi,a_mid,a_lo,a_ld,a_oe,a_bus), pk(0,0,0,0,1,0,8'h00));
        chk("R6", "release14", pk(b_ctl,b_hi,b_mid,b_lo,b_ld,b_oe,b_bus), pk(0,0,0,0,1,0,8'h00));

        // R7 with mode held: immediate sequence of current result
        @(negedge clk);
        mode = 1'b1;
        hs_seq("R7", words[2], 1'b0, 1'b1);

        // R6: conversion complete while mode is high starts a handshake
        load_result(16'h3C96, 1'b1, 1'b1);
        hs_seq("R6", 16'h3C96, 1'b1, 1'b1);

        // R10: result arriving mid-sequence is held back
        load_result(16'hF00F, 1'b0, 1'b0);
        hs_byte("R10", 0, 16'hF00F, 1'b0, 1'b0);
        load_result(16'h1234, 1'b1, 1'b0);
        hs_byte("R10", 1, 16'hF00F, 1'b0, 1'b0);
        hs_byte("R10", 2, 16'hF00F, 1'b0, 1'b0);
        hs_seq("R10", 16'h1234, 1'b1, 1'b0);

        // back to direct mode; R5 on full-scale word via middle group
        @(negedge clk);
        mode = 1'b0;
        load_result(16'hFFFF, 1'b1, 1'b1);
        @(negedge clk);
        mid_in = 1'b1;
        @(posedge clk);
        #1;
        chk("R5", "mid14", pk(b_ctl,b_hi,b_mid,b_lo,b_ld,b_oe,b_bus), pk(0,0,0,0,1,1,8'h3F));
        chk("R4", "mid16", pk(a_ctl,a_hi,a_mid,a_lo,a_ld,a_oe,a_bus), pk(0,0,0,0,1,1,8'hFF));

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule